// File: doc/BRIEF.md
# Quarter-Duty LCD Drive Sequencer

This block produces the drive level codes for a multiplexed liquid-crystal panel with four common lines and thirty-five segment lines. It runs at 1/4 duty with 1/3 bias. Each output line carries a 2-bit code that tells an external analog stage which of four voltages to apply: code 0 is ground, 1 is one third of the supply, 2 is two thirds and 3 is full supply. A frame is split into four equal slots, one per common line. The drive polarity flips on every frame so the panel sees no net DC.

The timing runs on the system clock. It advances only on cycles where the oscillator-rate enable is high. A 3-bit rate code picks the frame length from five divisors. The lowest four segment pins can be turned into static general-purpose outputs through a thermometer-style port count. Each port follows one display bit. Three controls force their own output states: segment blanking, power save and the active-low inhibit pin. The display store and the control fields are supplied as plain parallel inputs. Every pin of the block is a plain level signal, with no handshake.

Top module: `lcd_quad_seq`

## Requirements
- R1: After reset the sequencer is in slot 0 with positive polarity. The first frame uses the 384 divisor (96 ticks per slot) whatever the rate code is. With inhibit high and power save low, COM1 drives code 3 and COM2 to COM4 drive code 1.
- R2: Each slot lasts divisor/4 oscillator ticks. The rate code `rate_sel` is written MSB first: 3'b110 gives 768, 3'b111 gives 576, 3'b000 gives 384, 3'b001 gives 288 and 3'b010 gives 192. The unused codes 3'b011, 3'b100 and 3'b101 behave like 3'b000.
- R3: A change to `rate_sel` while running takes effect only at the next frame boundary. The slots of the current frame keep their old length.
- R4: Polarity toggles at the end of every frame. In positive polarity the selected common gives 3 and the others give 1; a lit segment gives 0 and a dark one gives 2. In negative polarity these become 0, 2, 3 and 1.
- R5: Segment pin n (1..35) during slot k (1..4) shows `disp_bits[4*(n-1)+k-1]`. Level codes are packed two bits per pin, pin 1 in `seg_lvl[1:0]` and COM1 in `com_lvl[1:0]`.
- R6: A `port_sel` value of 0 to 4 turns that many of the lowest segment pins into ports, starting from pin 1. Values 5 to 7 select no ports. `pin_is_port[k]` flags pin k+1 as a port.
- R7: A port pin k+1 drives a static 3 when `disp_bits[4*k]` is 1 and a static 0 when it is 0, independent of slot and polarity.
- R8: With `seg_off` high, every non-port segment pin shows the dark level for the current polarity, while the commons keep scanning.
- R9: With `pwr_save` high and inhibit high, `osc_en` is low, all commons and non-port segments give 0, and the ports keep their function. The timing is held at slot 0 with positive polarity. The slot length is reloaded from `rate_sel` while held.
- R10: With `inhibit_n` low, every common and segment pin gives 0, no pin is a port and `osc_en` is low. The timing is held as in R9.
- R11: The slot counter advances only on clock cycles where `osc_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator-rate clock enable |
| disp_bits | input | 140 | Display store, bit 0 is the first display bit |
| rate_sel | input | 3 | Frame divisor code |
| port_sel | input | 3 | Number of low segment pins used as ports |
| seg_off | input | 1 | Blank all segments |
| pwr_save | input | 1 | Power-save request |
| inhibit_n | input | 1 | Active-low display inhibit |
| osc_en | output | 1 | Oscillator enable |
| com_lvl | output | 8 | Common level codes, 2 bits per line |
| seg_lvl | output | 70 | Segment level codes, 2 bits per pin |
| pin_is_port | output | 4 | Low pins currently in port function |

## Verification
Slot and polarity changes come from registers. They appear one clock after the edge on which the last tick of a slot is taken. The level codes, port flags and `osc_en` follow the control and display inputs combinationally, in the same cycle. A behavioural model in the bench advances on each rising edge from the inputs held across that edge. All outputs are compared against it at the falling edge, after the registers have settled and before the stimulus changes. Slot lengths are measured in falling edges between changes of the common codes. Stimulus is applied two time units after a rising edge, so each measured count equals the number of ticks the requirement expects.

// File: rtl/lcdq_pkg.sv
package lcdq_pkg;
  typedef logic [1:0] lvl_t;

  localparam lvl_t LV_ZERO  = 2'd0;
  localparam lvl_t LV_THIRD = 2'd1;
  localparam lvl_t LV_TWO   = 2'd2;
  localparam lvl_t LV_FULL  = 2'd3;

  // ticks per slot; divisor/4 expressed as multiples of a unit of divisor/32
  function automatic int unsigned slot_ticks(input logic [2:0] code, input int unsigned unit);
    case (code)
      3'b110:  return 8 * unit;
      3'b111:  return 6 * unit;
      3'b001:  return 3 * unit;
      3'b010:  return 2 * unit;
      default: return 4 * unit;
    endcase
  endfunction
endpackage

// File: rtl/lcdq_frame_timer.sv
module lcdq_frame_timer
  import lcdq_pkg::*;
#(
  parameter int NUM_COM   = 4,
  parameter int SLOT_W    = 2,
  parameter int CNT_W     = 8,
  parameter int SLOT_UNIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              osc_tick,
  input  logic [2:0]        rate_sel,
  output logic [SLOT_W-1:0] slot,
  output logic              pol
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_COM - 1);
  localparam logic [CNT_W-1:0]  ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0]  RST_LEN   = CNT_W'(slot_ticks(3'b000, SLOT_UNIT));

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] new_len;

  assign new_len = CNT_W'(slot_ticks(rate_sel, SLOT_UNIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      slot <= '0;
      pol  <= 1'b0;
      len  <= RST_LEN;
    end else if (!run) begin
      cnt  <= '0;
      slot <= '0;
      pol  <= 1'b0;
      len  <= new_len;
    end else if (osc_tick) begin
      if (cnt == len - ONE) begin
        cnt <= '0;
        if (slot == LAST_SLOT) begin
          slot <= '0;
          pol  <= ~pol;
          len  <= new_len;
        end else begin
          slot <= slot + 1'b1;
        end
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end
endmodule

// File: rtl/lcdq_com_drive.sv
module lcdq_com_drive
  import lcdq_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int SLOT_W  = 2
) (
  input  logic [SLOT_W-1:0]    slot,
  input  logic                 pol,
  input  logic                 active,
  output logic [2*NUM_COM-1:0] com_lvl
);
  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    localparam logic [SLOT_W-1:0] IDX = SLOT_W'(c);
    lvl_t lv;
    always_comb begin
      if (!active)  lv = LV_ZERO;
      else if (pol) lv = (slot == IDX) ? LV_ZERO : LV_TWO;
      else          lv = (slot == IDX) ? LV_FULL : LV_THIRD;
    end
    assign com_lvl[2*c +: 2] = lv;
  end
endmodule

// File: rtl/lcdq_seg_drive.sv
module lcdq_seg_drive
  import lcdq_pkg::*;
#(
  parameter int NUM_SEG  = 35,
  parameter int NUM_COM  = 4,
  parameter int NUM_PORT = 4,
  parameter int SLOT_W   = 2,
  parameter int PSEL_W   = 3
) (
  input  logic [NUM_SEG*NUM_COM-1:0] disp,
  input  logic [SLOT_W-1:0]          slot,
  input  logic                       pol,
  input  logic                       active,
  input  logic                       seg_off,
  input  logic                       inhibit_n,
  input  logic [PSEL_W-1:0]          port_cnt,
  output logic [2*NUM_SEG-1:0]       seg_lvl,
  output logic [NUM_PORT-1:0]        is_port
);
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    logic [NUM_COM-1:0] grp;
    logic               lit;
    lvl_t               wave;

    assign grp = disp[i*NUM_COM +: NUM_COM];
    assign lit = grp[slot] & ~seg_off;

    always_comb begin
      if (!active)  wave = LV_ZERO;
      else if (pol) wave = lit ? LV_FULL : LV_THIRD;
      else          wave = lit ? LV_ZERO : LV_TWO;
    end

    if (i < NUM_PORT) begin : g_mux
      assign is_port[i]        = inhibit_n && (port_cnt > PSEL_W'(i));
      assign seg_lvl[2*i +: 2] = is_port[i] ? (grp[0] ? LV_FULL : LV_ZERO) : wave;
    end else begin : g_plain
      assign seg_lvl[2*i +: 2] = wave;
    end
  end
endmodule

// File: rtl/lcd_quad_seq.sv
module lcd_quad_seq
  import lcdq_pkg::*;
#(
  parameter int NUM_SEG   = 35,
  parameter int NUM_COM   = 4,
  parameter int NUM_PORT  = 4,
  parameter int SLOT_UNIT = 24,
  localparam int DISP_W   = NUM_SEG * NUM_COM,
  localparam int PSEL_W   = $clog2(NUM_PORT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 osc_tick,
  input  logic [DISP_W-1:0]    disp_bits,
  input  logic [2:0]           rate_sel,
  input  logic [PSEL_W-1:0]    port_sel,
  input  logic                 seg_off,
  input  logic                 pwr_save,
  input  logic                 inhibit_n,
  output logic                 osc_en,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl,
  output logic [NUM_PORT-1:0]  pin_is_port
);
  localparam int SLOT_W = $clog2(NUM_COM);
  localparam int CNT_W  = $clog2(8 * SLOT_UNIT + 1);

  logic              active;
  logic [SLOT_W-1:0] slot;
  logic              pol;
  logic [PSEL_W-1:0] port_cnt;

  assign active   = inhibit_n & ~pwr_save;
  assign osc_en   = active;
  assign port_cnt = (port_sel > PSEL_W'(NUM_PORT)) ? '0 : port_sel;

  lcdq_frame_timer #(
    .NUM_COM(NUM_COM), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .SLOT_UNIT(SLOT_UNIT)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .run(active), .osc_tick(osc_tick),
    .rate_sel(rate_sel), .slot(slot), .pol(pol)
  );

  lcdq_com_drive #(.NUM_COM(NUM_COM), .SLOT_W(SLOT_W)) u_com (
    .slot(slot), .pol(pol), .active(active), .com_lvl(com_lvl)
  );

  lcdq_seg_drive #(
    .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .NUM_PORT(NUM_PORT),
    .SLOT_W(SLOT_W), .PSEL_W(PSEL_W)
  ) u_seg (
    .disp(disp_bits), .slot(slot), .pol(pol), .active(active),
    .seg_off(seg_off), .inhibit_n(inhibit_n), .port_cnt(port_cnt),
    .seg_lvl(seg_lvl), .is_port(pin_is_port)
  );
endmodule

// File: rtl/lcd_quad_seq_chk.sv
module lcd_quad_seq_chk #(
  parameter int NUM_SEG  = 35,
  parameter int NUM_COM  = 4,
  parameter int NUM_PORT = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_SEG*NUM_COM-1:0]   disp_bits,
  input logic                         seg_off,
  input logic                         pwr_save,
  input logic                         inhibit_n,
  input logic                         osc_en,
  input logic [2*NUM_COM-1:0]         com_lvl,
  input logic [2*NUM_SEG-1:0]         seg_lvl,
  input logic [NUM_PORT-1:0]          pin_is_port
);
  logic [NUM_COM-1:0] extreme;
  logic               dark_ok;
  logic               plain_zero;

  always_comb begin
    for (int c = 0; c < NUM_COM; c++)
      extreme[c] = (com_lvl[2*c +: 2] == 2'd3) || (com_lvl[2*c +: 2] == 2'd0);
  end

  always_comb begin
    dark_ok    = (seg_lvl[2*NUM_PORT +: 2] == 2'd1) || (seg_lvl[2*NUM_PORT +: 2] == 2'd2);
    plain_zero = 1'b1;
    for (int i = NUM_PORT; i < NUM_SEG; i++) begin
      if (seg_lvl[2*i +: 2] != seg_lvl[2*NUM_PORT +: 2]) dark_ok = 1'b0;
      if (seg_lvl[2*i +: 2] != 2'd0) plain_zero = 1'b0;
    end
  end

  // R10
  inhibit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_n |-> (com_lvl == '0 && seg_lvl == '0 && pin_is_port == '0 && !osc_en));

  // R9
  pwr_save_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_n && pwr_save) |-> (!osc_en && com_lvl == '0 && plain_zero));

  // R4
  one_common_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |-> ($countones(extreme) == 1));

  // R8
  seg_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && seg_off) |-> dark_ok);

  // R6
  port_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_is_port + 1'b1) & pin_is_port) == '0);

  for (genvar k = 0; k < NUM_PORT; k++) begin : g_port_chk
    // R7
    port_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_is_port[k] && $past(pin_is_port[k]) && $stable(disp_bits[NUM_COM*k]))
        |-> $stable(seg_lvl[2*k +: 2]));
  end
endmodule

bind lcd_quad_seq lcd_quad_seq_chk #(
  .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .NUM_PORT(NUM_PORT)
) u_chk (.*);

// File: tb/lcd_quad_seq_test.sv
module lcd_quad_seq_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         osc_tick = 1'b1;
  logic [139:0] disp_bits = '0;
  logic [2:0]   rate_sel = 3'b000;
  logic [2:0]   port_sel = 3'b000;
  logic         seg_off = 1'b0;
  logic         pwr_save = 1'b0;
  logic         inhibit_n = 1'b1;
  logic         osc_en;
  logic [7:0]   com_lvl;
  logic [69:0]  seg_lvl;
  logic [3:0]   pin_is_port;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit tick_div = 0;
  int tcnt = 0;

  // reference model state
  int m_cnt = 0, m_slot = 0, m_pol = 0, m_len = 96;

  lcd_quad_seq uut (.*);

  always #4 clk = ~clk;

  function automatic int ticks_for(input logic [2:0] code);
    case (code)
      3'b110: return 192;
      3'b111: return 144;
      3'b001: return 72;
      3'b010: return 48;
      default: return 96;
    endcase
  endfunction

  function automatic bit m_run();
    return inhibit_n && !pwr_save;
  endfunction

  function automatic bit m_is_port(input int i);
    int n;
    n = (port_sel <= 3'd4) ? int'(port_sel) : 0;
    return inhibit_n && (i < 4) && (i < n);
  endfunction

  function automatic logic [1:0] m_com(input int c);
    if (!m_run()) return 2'd0;
    if (m_pol == 0) return (c == m_slot) ? 2'd3 : 2'd1;
    return (c == m_slot) ? 2'd0 : 2'd2;
  endfunction

  function automatic logic [1:0] m_seg(input int i);
    bit lit;
    if (m_is_port(i)) return disp_bits[4*i] ? 2'd3 : 2'd0;
    if (!m_run()) return 2'd0;
    lit = disp_bits[4*i + m_slot] && !seg_off;
    if (m_pol == 0) return lit ? 2'd0 : 2'd2;
    return lit ? 2'd3 : 2'd1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // oscillator enable pattern
  always @(posedge clk) begin
    #1;
    tcnt++;
    osc_tick = tick_div ? (tcnt % 3 == 0) : 1'b1;
  end

  // behavioural reference model, advanced at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_slot = 0; m_pol = 0; m_len = 96;
    end else if (!m_run()) begin
      m_cnt = 0; m_slot = 0; m_pol = 0; m_len = ticks_for(rate_sel);
    end else if (osc_tick) begin
      m_cnt++;
      if (m_cnt == m_len) begin
        m_cnt = 0;
        m_slot++;
        if (m_slot == 4) begin
          m_slot = 0;
          m_pol = 1 - m_pol;
          m_len = ticks_for(rate_sel);
        end
      end
    end
  end

  // full comparison at every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      logic [7:0]  ec;
      logic [69:0] es;
      logic [3:0]  ep;
      for (int c = 0; c < 4; c++) ec[2*c +: 2] = m_com(c);
      for (int i = 0; i < 35; i++) es[2*i +: 2] = m_seg(i);
      for (int k = 0; k < 4; k++) ep[k] = m_is_port(k);
      tag = !inhibit_n ? "R10" : pwr_save ? "R9" : seg_off ? "R8" : "R4";
      check(com_lvl == ec, tag, "com_lvl", com_lvl, ec);
      check(seg_lvl[69:8] == es[69:8], (tag == "R4") ? "R5" : tag, "seg_lvl", seg_lvl[69:8], es[69:8]);
      check(seg_lvl[7:0] == es[7:0], "R7", "low pins", seg_lvl[7:0], es[7:0]);
      check(pin_is_port == ep, "R6", "pin_is_port", pin_is_port, ep);
      check(osc_en == m_run(), tag, "osc_en", osc_en, m_run());
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // counts falling edges while com_lvl keeps its current value
  task automatic measure(output int n);
    logic [7:0] first;
    first = com_lvl;
    n = 1;
    forever begin
      @(negedge clk);
      if (com_lvl != first) break;
      n++;
    end
  endtask

  task automatic restart(input logic [2:0] code);
    step(); rate_sel = code; pwr_save = 1'b1;
    step(); pwr_save = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int n;
    logic [2:0] codes [8] = '{3'b110, 3'b111, 3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101};

    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(com_lvl == 8'b01_01_01_11, "R1", "reset com", com_lvl, 8'b01_01_01_11);
    measure(n);
    check(n == 96, "R1", "first slot length", n, 96);

    // R2 each divisor and the unused codes
    for (int j = 0; j < 8; j++) begin
      for (int b = 0; b < 140; b++) disp_bits[b] = $urandom_range(0, 1);
      restart(codes[j]);
      measure(n);
      check(n == ticks_for(codes[j]), "R2", "slot length", n, ticks_for(codes[j]));
      measure(n);
      check(n == ticks_for(codes[j]), "R2", "second slot length", n, ticks_for(codes[j]));
    end

    // R3 rate change mid-frame, R4 polarity flip at the boundary
    restart(3'b000);
    repeat (10) @(negedge clk);
    step(); rate_sel = 3'b010;
    @(negedge clk);
    measure(n);
    for (int s = 0; s < 3; s++) begin
      measure(n);
      check(n == 96, "R3", "old slot kept", n, 96);
    end
    check(com_lvl == 8'b10_10_10_00, "R4", "negative polarity com", com_lvl, 8'b10_10_10_00);
    measure(n);
    check(n == 48, "R3", "new slot length", n, 48);

    // R5 single lit bit: pin 8, slot 1
    disp_bits = '0;
    disp_bits[28] = 1'b1;
    restart(3'b110);
    check(seg_lvl[15:14] == 2'd0, "R5", "pin 8 lit", seg_lvl[15:14], 0);
    check(seg_lvl[17:16] == 2'd2, "R5", "pin 9 dark", seg_lvl[17:16], 2);

    // R6 R7 ports
    disp_bits[0] = 1'b1; disp_bits[4] = 1'b0; disp_bits[8] = 1'b1;
    step(); port_sel = 3'd3;
    @(negedge clk);
    check(pin_is_port == 4'b0111, "R6", "three ports", pin_is_port, 4'b0111);
    check(seg_lvl[5:0] == 6'b11_00_11, "R7", "port levels", seg_lvl[5:0], 6'b11_00_11);
    step(); port_sel = 3'd6;
    @(negedge clk);
    check(pin_is_port == 4'b0000, "R6", "code 6 no ports", pin_is_port, 0);
    step(); port_sel = 3'd4;

    // R8 blanking
    step(); seg_off = 1'b1;
    @(negedge clk);
    check(seg_lvl[69:8] != '0 && com_lvl != '0, "R8", "commons run", com_lvl, 1);
    repeat (400) @(negedge clk);
    step(); seg_off = 1'b0;

    // R9 power save keeps ports
    step(); pwr_save = 1'b1;
    @(negedge clk);
    check(pin_is_port == 4'b1111 && seg_lvl[1:0] == 2'd3, "R9", "ports kept", seg_lvl[1:0], 3);
    check(osc_en == 1'b0, "R9", "osc_en", osc_en, 0);
    repeat (20) @(negedge clk);
    step(); pwr_save = 1'b0;

    // R10 inhibit
    step(); inhibit_n = 1'b0;
    @(negedge clk);
    check(seg_lvl == '0 && pin_is_port == '0, "R10", "all low", seg_lvl[7:0], 0);
    repeat (20) @(negedge clk);
    step(); inhibit_n = 1'b1;

    // R11 gated ticks
    tick_div = 1;
    restart(3'b010);
    measure(n);
    measure(n);
    check(n == 144, "R11", "slot of 48 ticks at 1 in 3", n, 144);
    tick_div = 0;
    repeat (50) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule